// File: doc/BRIEF.md
# Logical Port to Identifier Mapper

This block translates 8-bit logical port numbers on one packet interface into 6-bit logical identifiers. A 256-entry programmable table, indexed by port number, holds for every port an identifier, an enable flag and a flag that selects bit reversal within each byte. Software programs the table through a simple register write/read port. Each write is checked against two mapping rules before it is committed. A write that breaks a rule leaves the table untouched and returns an error code on a short response channel.

On the data side, bytes arrive tagged with a logical port. The block looks up the port's entry and emits each byte one cycle later, tagged with the mapped identifier. The byte is bit-reversed when the entry asks for it. A byte for a port whose entry is not enabled is discarded and raises an inactive-port event that carries the port number. A separate status lookup reports whether a port can accept data. A disabled port always reads as available. An enabled port reports the availability flag of its identifier, which is supplied from outside.

Top module: `lport_id_mapper`

## Requirements
- R1: After reset every table entry reads as 0x00. A read request returns the entry at the requested port number on `rd_data` with `rd_valid` high, exactly one cycle after the request.
- R2: Entry layout: bits [5:0] are the identifier, bit 6 is the enable (1 = connected) and bit 7 is bit reversal (1 = reverse). Writing 0x45 to port 0x08 maps port 8 to identifier 5, enabled, not reversed. Writing 0x7F to port 0xFF maps port 255 to identifier 63, enabled.
- R3: At most MAX_EN entries are enabled at once. A write that would enable a further entry while MAX_EN are already enabled is dropped with response code 1.
- R4: A write that would enable an entry with an identifier that another enabled entry holds is dropped with response code 2. Disabled entries never take part in this check. When both rules are broken, code 1 is returned.
- R5: Rewriting an enabled entry with its own identifier is accepted, including a change to its reversal bit only, even while MAX_EN entries are enabled. Disabling an entry frees its identifier and one enable slot. A write with bit 6 clear is always accepted.
- R6: Each write strobe produces exactly one response: `rsp_valid` high for one cycle, one cycle after the strobe. `rsp_code` is 0 when the write was accepted and committed.
- R7: A byte presented on an enabled port appears one cycle later on `out_byte` with `out_valid` high. `out_id` carries that port's identifier.
- R8: When the entry's reversal bit is set, output bit i equals input bit 7-i. Otherwise the byte passes through unchanged.
- R9: A byte presented on a disabled port produces no `out_valid`. Instead `inact_valid` pulses one cycle later, with `inact_port` equal to the port number.
- R10: A status query returns `st_avail` one cycle later with `st_rsp_valid` high. A disabled port reports 1. An enabled port reports `id_avail[identifier]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Port number of the entry to write |
| wr_data | input | 8 | New entry value |
| rsp_valid | output | 1 | Write response valid |
| rsp_code | output | 2 | 0 accepted, 1 enable limit, 2 identifier in use |
| rd_en | input | 1 | Table read strobe |
| rd_addr | input | 8 | Port number of the entry to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Entry value read |
| in_valid | input | 1 | Data byte valid |
| in_port | input | 8 | Logical port of the data byte |
| in_byte | input | 8 | Data byte |
| out_valid | output | 1 | Mapped byte valid |
| out_id | output | 6 | Identifier of the mapped byte |
| out_byte | output | 8 | Mapped, optionally reversed, byte |
| inact_valid | output | 1 | Inactive-port event pulse |
| inact_port | output | 8 | Port number that caused the event |
| st_valid | input | 1 | Status query strobe |
| st_port | input | 8 | Port number queried |
| id_avail | input | 64 | Availability flag per identifier |
| st_rsp_valid | output | 1 | Status answer valid |
| st_avail | output | 1 | Availability answer |

## Verification
The bench keeps the full 8-bit port and 6-bit identifier widths. It lowers MAX_EN to 4, so the enable limit is reached after four accepted writes. That makes the limit rejection, the precedence of the limit over the duplicate check, and slot recovery after a disable reachable within a few dozen cycles. With the full port range in place, the boundary entry at port 0xFF and identifier 63 is still exercised, together with the reversal and discard paths.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_LIMIT = 2'd1,
    RSP_DUPID = 2'd2
  } rsp_e;
endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
  parameter int PORT_W = 8,
  parameter int ENT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PORT_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [PORT_W-1:0] chk_addr,
  output logic [ENT_W-1:0]  chk_ent,
  input  logic [PORT_W-1:0] dp_addr,
  output logic [ENT_W-1:0]  dp_ent,
  input  logic [PORT_W-1:0] st_addr,
  output logic [ENT_W-2:0]  st_ent,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [ENT_W-1:0]  rd_data
);
  localparam int PORTS = 1 << PORT_W;

  logic [ENT_W-1:0] mem [PORTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PORTS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign chk_ent = mem[chk_addr];
  assign dp_ent  = mem[dp_addr];
  assign st_ent  = mem[st_addr][ENT_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

  assert_rd_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/lpm_rules.sv
module lpm_rules
  import lpm_pkg::*;
#(
  parameter int ID_W   = 6,
  parameter int MAX_EN = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [ID_W:0] new_ent,
  input  logic [ID_W:0] old_ent,
  output logic          accept,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code
);
  localparam int IDS   = 1 << ID_W;
  localparam int CNT_W = $clog2(MAX_EN + 1);

  logic [IDS-1:0]   in_use, use_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [ID_W-1:0]  new_id, old_id;
  logic             new_on, old_on, same_own, limit_hit, dup_hit;
  rsp_e             code;

  assign new_id = new_ent[ID_W-1:0];
  assign new_on = new_ent[ID_W];
  assign old_id = old_ent[ID_W-1:0];
  assign old_on = old_ent[ID_W];

  always_comb begin
    same_own  = old_on && (old_id == new_id);
    limit_hit = new_on && !old_on && (cnt == CNT_W'(MAX_EN));
    dup_hit   = new_on && in_use[new_id] && !same_own;
    if (limit_hit)    code = RSP_LIMIT;
    else if (dup_hit) code = RSP_DUPID;
    else              code = RSP_OK;
    accept = wr_en && (code == RSP_OK);
  end

  always_comb begin
    use_nxt = in_use;
    if (old_on) use_nxt[old_id] = 1'b0;
    if (new_on) use_nxt[new_id] = 1'b1;
    cnt_nxt = cnt;
    if (new_on && !old_on) cnt_nxt = cnt + 1'b1;
    else if (!new_on && old_on) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_use    <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
    end else begin
      rsp_valid <= wr_en;
      if (wr_en) rsp_code <= code;
      if (accept) begin
        in_use <= use_nxt;
        cnt    <= cnt_nxt;
      end
    end
  end

  initial begin
    assert_param_R3: assert (MAX_EN <= IDS && MAX_EN > 0);
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_EN));

  assert_cnt_map_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(in_use) == int'(cnt));

  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RSP_OK) |-> ($stable(cnt) && $stable(in_use)));

  assert_rsp_once_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rsp_valid);

  assert_rsp_none_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !rsp_valid);
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath #(
  parameter int PORT_W = 8,
  parameter int ID_W   = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [ID_W+1:0]   ent,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [BYTE_W-1:0] out_byte,
  output logic              inact_valid,
  output logic [PORT_W-1:0] inact_port
);
  logic [BYTE_W-1:0] flipped, chosen;
  logic              on, rev;

  assign on  = ent[ID_W];
  assign rev = ent[ID_W+1];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_flip
    assign flipped[g] = in_byte[BYTE_W-1-g];
  end

  assign chosen = rev ? flipped : in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_id      <= '0;
      out_byte    <= '0;
      inact_valid <= 1'b0;
      inact_port  <= '0;
    end else begin
      out_valid   <= in_valid && on;
      inact_valid <= in_valid && !on;
      if (in_valid && on) begin
        out_id   <= ent[ID_W-1:0];
        out_byte <= chosen;
      end
      if (in_valid && !on) inact_port <= in_port;
    end
  end

  assert_drop_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && inact_valid));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || inact_valid));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || inact_valid));
endmodule

// File: rtl/lport_id_mapper.sv
module lport_id_mapper
  import lpm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ID_W   = 6,
  parameter int MAX_EN = 64,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PORT_W-1:0]      wr_addr,
  input  logic [ID_W+1:0]        wr_data,
  output logic                   rsp_valid,
  output logic [1:0]             rsp_code,
  input  logic                   rd_en,
  input  logic [PORT_W-1:0]      rd_addr,
  output logic                   rd_valid,
  output logic [ID_W+1:0]        rd_data,
  input  logic                   in_valid,
  input  logic [PORT_W-1:0]      in_port,
  input  logic [BYTE_W-1:0]      in_byte,
  output logic                   out_valid,
  output logic [ID_W-1:0]        out_id,
  output logic [BYTE_W-1:0]      out_byte,
  output logic                   inact_valid,
  output logic [PORT_W-1:0]      inact_port,
  input  logic                   st_valid,
  input  logic [PORT_W-1:0]      st_port,
  input  logic [(1<<ID_W)-1:0]   id_avail,
  output logic                   st_rsp_valid,
  output logic                   st_avail
);
  localparam int ENT_W = ID_W + 2;

  logic [ENT_W-1:0] old_ent, dp_ent;
  logic [ENT_W-2:0] st_ent;
  logic             accept;

  lpm_table #(.PORT_W(PORT_W), .ENT_W(ENT_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .we       (accept),
    .waddr    (wr_addr),
    .wdata    (wr_data),
    .chk_addr (wr_addr),
    .chk_ent  (old_ent),
    .dp_addr  (in_port),
    .dp_ent   (dp_ent),
    .st_addr  (st_port),
    .st_ent   (st_ent),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  lpm_rules #(.ID_W(ID_W), .MAX_EN(MAX_EN)) u_rules (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .new_ent   (wr_data[ID_W:0]),
    .old_ent   (old_ent[ID_W:0]),
    .accept    (accept),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
  );

  lpm_datapath #(.PORT_W(PORT_W), .ID_W(ID_W), .BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_port     (in_port),
    .in_byte     (in_byte),
    .ent         (dp_ent),
    .out_valid   (out_valid),
    .out_id      (out_id),
    .out_byte    (out_byte),
    .inact_valid (inact_valid),
    .inact_port  (inact_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_rsp_valid <= 1'b0;
      st_avail     <= 1'b0;
    end else begin
      st_rsp_valid <= st_valid;
      if (st_valid) st_avail <= !st_ent[ID_W] || id_avail[st_ent[ID_W-1:0]];
    end
  end

  assert_st_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> st_rsp_valid);

  assert_st_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ent[ID_W]) |=> st_avail);
endmodule

// File: tb/lport_id_mapper_bench.sv
module lport_id_mapper_bench;
  localparam int PORT_W = 8;
  localparam int ID_W   = 6;
  localparam int MAX_EN = 4;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        wr_en = 0, rd_en = 0, in_valid = 0, st_valid = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0, in_port = 0, st_port = 0, wr_data = 0, in_byte = 0;
  logic [63:0] id_avail = 64'h0F0F_0000_FFFF_0020;
  logic        rsp_valid, rd_valid, out_valid, inact_valid, st_rsp_valid, st_avail;
  logic [1:0]  rsp_code;
  logic [7:0]  rd_data, out_byte, inact_port;
  logic [5:0]  out_id;

  lport_id_mapper #(.PORT_W(PORT_W), .ID_W(ID_W), .MAX_EN(MAX_EN), .BYTE_W(BYTE_W)) u_lport_id_mapper (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .in_valid(in_valid), .in_port(in_port),
    .in_byte(in_byte), .out_valid(out_valid), .out_id(out_id), .out_byte(out_byte),
    .inact_valid(inact_valid), .inact_port(inact_port), .st_valid(st_valid),
    .st_port(st_port), .id_avail(id_avail), .st_rsp_valid(st_rsp_valid), .st_avail(st_avail)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mdl [256];
  logic [1:0]  q_rsp[$];  string t_rsp[$];
  logic [7:0]  q_rd[$];   string t_rd[$];
  logic [13:0] q_out[$];  string t_out[$];
  logic [7:0]  q_ev[$];   string t_ev[$];
  logic        q_st[$];   string t_st[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_code(logic [7:0] a, logic [7:0] d);
    int on_cnt = 0;
    bit dup = 0;
    for (int p = 0; p < 256; p++) begin
      if (mdl[p][6]) begin
        on_cnt++;
        if (p != int'(a) && mdl[p][5:0] == d[5:0]) dup = 1;
      end
    end
    if (!d[6]) return 2'd0;
    if (!mdl[a][6] && on_cnt >= MAX_EN) return 2'd1;
    if (dup) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [7:0] mirror(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic do_write(logic [7:0] a, logic [7:0] d, string tag);
    logic [1:0] c = model_code(a, d);
    q_rsp.push_back(c); t_rsp.push_back(tag);
    if (c == 2'd0) mdl[a] = d;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic do_read(logic [7:0] a, string tag);
    q_rd.push_back(mdl[a]); t_rd.push_back(tag);
    rd_en = 1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic send(logic [7:0] p, logic [7:0] b, string tag);
    logic [7:0] e = mdl[p];
    if (e[6]) begin
      q_out.push_back({e[5:0], e[7] ? mirror(b) : b}); t_out.push_back(tag);
    end else begin
      q_ev.push_back(p); t_ev.push_back(tag);
    end
    in_valid = 1; in_port = p; in_byte = b;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic query(logic [7:0] p, string tag);
    logic [7:0] e = mdl[p];
    q_st.push_back(e[6] ? id_avail[e[5:0]] : 1'b1); t_st.push_back(tag);
    st_valid = 1; st_port = p;
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (q_rsp.size() == 0) check("R6 unexpected rsp", 1, 0);
        else check(t_rsp.pop_front(), rsp_code, q_rsp.pop_front());
      end
      if (rd_valid) begin
        if (q_rd.size() == 0) check("R1 unexpected read", 1, 0);
        else check(t_rd.pop_front(), rd_data, q_rd.pop_front());
      end
      if (out_valid) begin
        if (q_out.size() == 0) check("R9 unexpected out_valid", 1, 0);
        else check(t_out.pop_front(), {out_id, out_byte}, q_out.pop_front());
      end
      if (inact_valid) begin
        if (q_ev.size() == 0) check("R9 unexpected event", 1, 0);
        else check(t_ev.pop_front(), inact_port, q_ev.pop_front());
      end
      if (st_rsp_valid) begin
        if (q_st.size() == 0) check("R10 unexpected status", 1, 0);
        else check(t_st.pop_front(), st_avail, q_st.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 256; p++) mdl[p] = 8'h00;
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    check("R1 reset outputs", {rsp_valid, rd_valid, out_valid, inact_valid, st_rsp_valid}, 0);
    @(posedge clk); #1;
    do_read(8'h08, "R1 reset entry 0x08");
    do_read(8'hFF, "R1 reset entry 0xFF");
    do_write(8'h08, 8'h45, "R2 map 8 to id 5");
    do_read(8'h08, "R2 readback 0x45");
    do_write(8'hFF, 8'h7F, "R2 map 255 to id 63");
    do_read(8'hFF, "R2 readback 0x7F");
    do_write(8'h10, 8'h43, "R6 accept id 3");
    do_write(8'h20, 8'h45, "R4 duplicate id 5");
    do_read(8'h20, "R4 rejected entry stays 0");
    do_write(8'h50, 8'h05, "R5 disabled write with used id");
    do_write(8'h30, 8'h44, "R6 accept id 4 fills limit");
    do_write(8'h40, 8'h50, "R3 fifth enable rejected");
    do_write(8'h40, 8'h45, "R3 limit before duplicate");
    do_read(8'h40, "R3 rejected entry stays 0");
    do_write(8'h08, 8'hC5, "R5 same id set reversal at limit");
    do_write(8'h10, 8'h03, "R5 disable frees slot");
    do_write(8'h40, 8'h43, "R5 reuse freed id 3");
    do_read(8'h40, "R5 readback 0x43");
    send(8'h08, 8'h01, "R8 reversed 0x01");
    send(8'h08, 8'hA6, "R8 reversed 0xA6");
    send(8'hFF, 8'hA6, "R7 plain byte on port 255");
    send(8'h10, 8'h55, "R9 drop disabled port 0x10");
    send(8'h40, 8'h3C, "R7 port 0x40 id 3");
    send(8'h77, 8'hFF, "R9 drop never enabled 0x77");
    query(8'h10, "R10 disabled reports available");
    query(8'h08, "R10 id 5 available flag");
    query(8'h40, "R10 id 3 available flag");
    query(8'hFF, "R10 id 63 available flag");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 pending responses", q_rsp.size(), 0);
    check("R7 pending outputs", q_out.size(), 0);
    check("R9 pending events", q_ev.size(), 0);
    check("R10 pending status", q_st.size() + q_rd.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule